// File: doc/BRIEF.md
# Dual-Register Phase Accumulator for Direct Digital Synthesis

This block is the numeric core of a direct digital synthesizer. A 48-bit phase word grows by a chosen increment on every sample clock. The upper 15 bits of that word address a waveform table that lies outside the block. The sample clock is nominally 10 MHz. The increment sets the output frequency: a larger increment walks the table faster.

Two 48-bit increment registers, A and B, are held in the block. The host loads each one a byte at a time through an 8-bit write port. The adder reads one register while the host rewrites the other. The active register comes from one of two sources:

- a mode bit driven by the host;
- an external frequency-shift-keying pin, brought in through a two-flop synchronizer.

Switching between A and B happens between two adds, so every sample clock performs exactly one add.

Selection is kept in a two-state machine.

| State | Meaning |
|---|---|
| `SEL_A` | Register A feeds the adder. |
| `SEL_B` | Register B feeds the adder. |

| Transition | Condition |
|---|---|
| `A_TO_B` | Taken from `SEL_A` when the wanted selection is B. |
| `B_TO_A` | Taken from `SEL_B` when the wanted selection is A. |
| `HOLD_A` / `HOLD_B` | The state is kept when the wanted selection matches it. |

Synchronous reset forces `SEL_A`.

Top module: `dds_phase_core`

## Requirements
- R1: On every clock edge with `rst` low, `phase` becomes its previous value plus the increment of the register active before that edge.
- R2: `rom_addr` always equals `phase[47:33]`.
- R3: A write loads one byte into one register at a clock edge where `wr_en` is high. `wr_sel_b` picks the register (0 = A, 1 = B). `wr_byte` = k (0..5) loads bits 8k+7:8k of that register, so byte 0 is the least significant. The new value feeds the add at the following edge.
- R4: A write with `wr_byte` equal to 6 or 7 changes neither register.
- R5: Writing the inactive register leaves the increment used by the current adds unchanged.
- R6: When `sel_src_fsk` is 0, `sel_reg_b` (0 = A, 1 = B) sampled at edge k sets `active_b` after edge k. The first add that uses the new register is the one at edge k+1.
- R7: When `sel_src_fsk` is 1, a level on `fsk_in` captured at edge k appears on `active_b` after edge k+2. The first add with the new register is at edge k+3.
- R8: A change of active register neither skips nor repeats an add. Exactly one add happens per clock.
- R9: When `rst` is high at an edge, that edge clears `phase`, both registers and the synchronizer, and selects A.
- R10: Additions wrap modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_sel_b | input | 1 | Write target: 0 = register A, 1 = register B |
| wr_byte | input | 3 | Byte index, 0 = least significant |
| wr_data | input | 8 | Byte value |
| sel_src_fsk | input | 1 | Selection source: 1 = `fsk_in`, 0 = `sel_reg_b` |
| sel_reg_b | input | 1 | Host selection bit |
| fsk_in | input | 1 | Asynchronous frequency-shift-keying level |
| phase | output | 48 | Phase accumulator |
| rom_addr | output | 15 | Waveform table address |
| active_b | output | 1 | 1 when register B feeds the adder |

## Verification
A byte write shows up in `phase` one edge later than the write edge: the write edge stores the byte, and the next edge's add uses it. The selection bit reaches `active_b` after one edge and reaches `phase` after two. A level on `fsk_in` reaches `active_b` after three edges and reaches `phase` after four. The bench changes inputs only at falling edges. After each rising edge it advances a spec-level reference once, in that same register order, and compares `phase`, `rom_addr` and `active_b` at the following falling edge. Every result is therefore checked in the exact cycle it is due.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Which increment register feeds the adder
    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_state_t;

endpackage

// File: rtl/dds_sync.sv
// Multi-flop level synchronizer with synchronous clear
module dds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dds_inc_bank.sv
// Two byte-loaded increment registers
module dds_inc_bank #(
    parameter int ACC_W  = 48,
    parameter int BYTE_W = 8,
    localparam int NBYTES  = ACC_W / BYTE_W,
    localparam int BYTE_AW = $clog2(NBYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel_b,
    input  logic [BYTE_AW-1:0] wr_byte,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [ACC_W-1:0]   inc_a,
    output logic [ACC_W-1:0]   inc_b
);

    logic [ACC_W-1:0] bank [2];

    genvar r, b;
    generate
        for (r = 0; r < 2; r++) begin : g_reg
            for (b = 0; b < NBYTES; b++) begin : g_byte
                logic              hit;
                logic [BYTE_W-1:0] byte_q;

                assign hit = wr_en && (wr_sel_b == 1'(r)) && (wr_byte == BYTE_AW'(b));

                always_ff @(posedge clk) begin
                    if (rst)      byte_q <= '0;
                    else if (hit) byte_q <= wr_data;
                end

                assign bank[r][b*BYTE_W +: BYTE_W] = byte_q;
            end
        end
    endgenerate

    assign inc_a = bank[0];
    assign inc_b = bank[1];

endmodule

// File: rtl/dds_sel_fsm.sv
// Register-select state machine; switches between adds
module dds_sel_fsm
    import dds_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             want_b,
    input  logic [ACC_W-1:0] inc_a,
    input  logic [ACC_W-1:0] inc_b,
    output logic             active_b,
    output logic [ACC_W-1:0] inc_sel
);

    sel_state_t state_q, state_d;

    // next state: A_TO_B, B_TO_A, or hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_A: if (want_b)  state_d = SEL_B;
            SEL_B: if (!want_b) state_d = SEL_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEL_A;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEL_A: begin
                active_b = 1'b0;
                inc_sel  = inc_a;
            end
            SEL_B: begin
                active_b = 1'b1;
                inc_sel  = inc_b;
            end
        endcase
    end

endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator and table address
module dds_phase_acc #(
    parameter int ACC_W  = 48,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  inc,
    output logic [ACC_W-1:0]  phase,
    output logic [ADDR_W-1:0] rom_addr
);

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_q + inc;
    end

    assign phase    = acc_q;
    assign rom_addr = acc_q[ACC_W-1 -: ADDR_W];

endmodule

// File: rtl/dds_phase_core.sv
// Top: dual increment registers, selection and accumulator
module dds_phase_core #(
    parameter int ACC_W       = 48,
    parameter int ADDR_W      = 15,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NBYTES  = ACC_W / BYTE_W,
    localparam int BYTE_AW = $clog2(NBYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel_b,
    input  logic [BYTE_AW-1:0] wr_byte,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               sel_src_fsk,
    input  logic               sel_reg_b,
    input  logic               fsk_in,
    output logic [ACC_W-1:0]   phase,
    output logic [ADDR_W-1:0]  rom_addr,
    output logic               active_b
);

    logic [ACC_W-1:0] inc_a, inc_b, inc_sel;
    logic             fsk_s, want_b;

    dds_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(fsk_in),
        .q_sync (fsk_s)
    );

    assign want_b = sel_src_fsk ? fsk_s : sel_reg_b;

    dds_inc_bank #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel_b(wr_sel_b),
        .wr_byte (wr_byte),
        .wr_data (wr_data),
        .inc_a   (inc_a),
        .inc_b   (inc_b)
    );

    dds_sel_fsm #(.ACC_W(ACC_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .want_b  (want_b),
        .inc_a   (inc_a),
        .inc_b   (inc_b),
        .active_b(active_b),
        .inc_sel (inc_sel)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc_sel),
        .phase   (phase),
        .rom_addr(rom_addr)
    );

endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
    parameter int ACC_W   = 48,
    parameter int ADDR_W  = 15,
    parameter int BYTE_AW = 3,
    parameter int NBYTES  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               wr_sel_b,
    input logic [BYTE_AW-1:0] wr_byte,
    input logic               sel_src_fsk,
    input logic               sel_reg_b,
    input logic [ACC_W-1:0]   phase,
    input logic [ADDR_W-1:0]  rom_addr,
    input logic               active_b,
    input logic               want_b,
    input logic [ACC_W-1:0]   inc_a,
    input logic [ACC_W-1:0]   inc_b,
    input logic [ACC_W-1:0]   inc_sel
);

    // R1, R8, R10: one add per clock, wrapping
    a_r1_one_add_per_clock: assert property (@(posedge clk) disable iff (rst)
        !rst |=> phase == $past(phase) + $past(inc_sel));

    a_r2_addr_from_phase: assert property (@(posedge clk) disable iff (rst)
        !rst |-> rom_addr == phase[ACC_W-1 -: ADDR_W]);

    a_r4_high_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_byte) >= NBYTES)) |=> ($stable(inc_a) && $stable(inc_b)));

    a_r5_inactive_write_isolated: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel_b != active_b) && (want_b == active_b)) |=> $stable(inc_sel));

    a_r6_host_select: assert property (@(posedge clk) disable iff (rst)
        !sel_src_fsk |=> active_b == $past(sel_reg_b));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (phase == '0 && !active_b && inc_a == '0 && inc_b == '0));

endmodule

bind dds_phase_core dds_phase_core_chk #(
    .ACC_W  (ACC_W),
    .ADDR_W (ADDR_W),
    .BYTE_AW(BYTE_AW),
    .NBYTES (NBYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel_b   (wr_sel_b),
    .wr_byte    (wr_byte),
    .sel_src_fsk(sel_src_fsk),
    .sel_reg_b  (sel_reg_b),
    .phase      (phase),
    .rom_addr   (rom_addr),
    .active_b   (active_b),
    .want_b     (want_b),
    .inc_a      (inc_a),
    .inc_b      (inc_b),
    .inc_sel    (inc_sel)
);

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel_b = 1'b0;
    logic [2:0]  wr_byte = '0;
    logic [7:0]  wr_data = '0;
    logic        sel_src_fsk = 1'b0, sel_reg_b = 1'b0, fsk_in = 1'b0;
    logic [47:0] phase;
    logic [14:0] rom_addr;
    logic        active_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    logic [47:0] m_acc;
    logic [47:0] m_inc [2];
    logic        m_sel, m_s1, m_s2;

    always #5 clk = ~clk;

    dds_phase_core uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_b(wr_sel_b),
        .wr_byte(wr_byte), .wr_data(wr_data), .sel_src_fsk(sel_src_fsk),
        .sel_reg_b(sel_reg_b), .fsk_in(fsk_in), .phase(phase),
        .rom_addr(rom_addr), .active_b(active_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: reference advanced with the inputs seen at the edge
    task automatic step(input string tag);
        logic nsel;
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_inc[0] = '0; m_inc[1] = '0;
            m_sel = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
        end else begin
            m_acc = m_acc + m_inc[m_sel];
            if (wr_en && wr_byte < 3'd6)
                m_inc[wr_sel_b][wr_byte*8 +: 8] = wr_data;
            nsel  = sel_src_fsk ? m_s2 : sel_reg_b;
            m_s2  = m_s1;
            m_s1  = fsk_in;
            m_sel = nsel;
        end
        @(negedge clk);
        chk(tag, 64'(phase), 64'(m_acc));
        chk("R2", 64'(rom_addr), 64'(m_acc[47:33]));
        chk(tag, 64'(active_b), 64'(m_sel));
    endtask

    task automatic load(input logic reg_b, input logic [47:0] val, input string tag);
        for (int b = 0; b < 6; b++) begin
            wr_en = 1'b1; wr_sel_b = reg_b; wr_byte = 3'(b); wr_data = val[b*8 +: 8];
            step(tag);
        end
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; sel_src_fsk = 1'b0; sel_reg_b = 1'b0; fsk_in = 1'b0;
        step("R9");
        step("R9");
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk("R9", 64'(phase), 64'd0);
        chk("R9", 64'(active_b), 64'd0);

        // R10: B = all ones, A stays zero; switch to B and wrap below zero
        load(1'b1, 48'hFFFF_FFFF_FFFF, "R5");
        chk("R5", 64'(phase), 64'd0);
        sel_reg_b = 1'b1;
        step("R6");
        chk("R6", 64'(active_b), 64'd1);
        chk("R6", 64'(phase), 64'd0);
        step("R10");
        chk("R10", 64'(phase), 64'hFFFF_FFFF_FFFF);

        // R4: writes to byte 6 and 7 of the active register are ignored
        wr_en = 1'b1; wr_sel_b = 1'b1; wr_byte = 3'd6; wr_data = 8'h00;
        step("R4");
        wr_byte = 3'd7;
        step("R4");
        wr_en = 1'b0;
        step("R4");
        chk("R4", 64'(phase), 64'hFFFF_FFFF_FFFF - 64'd3);

        // R3/R5/R8: A known, then rewrite B while switching mid-load
        sel_reg_b = 1'b0;
        load(1'b0, 48'h0000_1000_0001, "R3");
        for (int b = 0; b < 6; b++) begin
            wr_en = 1'b1; wr_sel_b = 1'b1; wr_byte = 3'(b); wr_data = 8'(8'h11 * (b + 1));
            if (b == 3) sel_reg_b = 1'b1;
            step("R8");
        end
        wr_en = 1'b0;
        sel_reg_b = 1'b0;
        step("R8");
        step("R8");

        // R7: FSK path, three edges to active_b
        sel_src_fsk = 1'b1;
        fsk_in = 1'b1;
        step("R7");
        chk("R7", 64'(active_b), 64'd0);
        step("R7");
        chk("R7", 64'(active_b), 64'd0);
        step("R7");
        chk("R7", 64'(active_b), 64'd1);
        fsk_in = 1'b0;
        repeat (4) step("R7");
        chk("R7", 64'(active_b), 64'd0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            wr_en    = ($urandom % 2) == 0;
            wr_sel_b = 1'($urandom);
            wr_byte  = 3'($urandom);
            wr_data  = 8'($urandom);
            if ($urandom % 16 == 0) sel_reg_b = ~sel_reg_b;
            if ($urandom % 64 == 0) sel_src_fsk = ~sel_src_fsk;
            if ($urandom % 8 == 0)  fsk_in = ~fsk_in;
            if ($urandom % 1500 == 0) rst = 1'b1;
            step(rst ? "R9" : "R1");
            rst = 1'b0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule